// File: doc/BRIEF.md
# Serial Overhead Row Transmitter

This block sends one row of transport overhead bytes per payload row over a one-bit serial link. It runs on a free-running overhead clock. Alongside the data bit it drives a clock-enable and a one-cycle row-start pulse. Each row holds 36 bytes: three overhead slots for each of 12 constituent streams. That is 288 bits, sent as one unbroken burst with the most significant bit of each byte first.

The user writes the next row into a shadow bank of a double-buffered row store, one byte per load strobe. The shadow bank becomes the active bank at the moment a row is launched. Each payload row window is marked by a start pulse and an end pulse. The overhead for the next row is sent inside that window, with four idle guard cycles kept at each of its edges.

The block measures each window and uses the last measured length to decide whether the next window can hold a full burst plus both guard bands. If it cannot, the block reports an underrun and sends nothing in that window.

Top module: `ovh_row_tx`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, ovh_en_o, ovh_sd_o, ovh_fp_o and underrun_o are all 0.
- R2: When a row is launched from a start pulse, ovh_en_o is high for exactly 288 consecutive cycles. The first of these is the fifth cycle of the window, counting the start-pulse cycle as the first.
- R3: Bits go out most significant bit first. Buffer bytes go out in index order 0 to 35, so the first bit of a row is bit 7 of byte 0.
- R4: ovh_fp_o is high for one cycle only: the first enable cycle of each row.
- R5: ovh_sd_o is 0 in every cycle in which ovh_en_o is 0.
- R6: Window length counts the cycles from the start-pulse cycle through the end-pulse cycle, inclusive. A start pulse launches a row only if the last measured length is at least 296. Otherwise underrun_o pulses high for one cycle, in the cycle after the start pulse, no row is sent and the banks do not swap.
- R7: Before any window has been measured, a start pulse launches no row and raises no underrun.
- R8: Each load strobe writes load_byte_i into the shadow bank at the next index, counting from 0 after each swap. The active and shadow banks trade places on the clock edge that ends the cycle before the row-start pulse. Loads made while a row is being sent affect only the following row.
- R9: A load strobe sampled on the swap edge writes index 0 of the new shadow bank. The next load then writes index 1.
- R10: Load strobes after 36 bytes have been written since the last swap are ignored and change no stored byte.
- R11: ovh_en_o stays low during the last four cycles of a window of the minimum length of 296.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running overhead clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_start_i | input | 1 | One-cycle pulse at the first cycle of a payload row window |
| win_end_i | input | 1 | One-cycle pulse at the last cycle of a payload row window |
| load_i | input | 1 | Byte write strobe into the shadow bank |
| load_byte_i | input | 8 | Byte written on load_i |
| ovh_sd_o | output | 1 | Serial overhead data bit |
| ovh_en_o | output | 1 | High while a valid bit is on ovh_sd_o |
| ovh_fp_o | output | 1 | Row-start pulse, high with the first bit of a row |
| underrun_o | output | 1 | One-cycle pulse when the predicted window is too short |

## Verification
Two functions can meet in the same cycle: a user load and the bank swap that launches a row. The bench provokes this by driving the first byte of the next row in the fourth window cycle, which is the cycle sampled by the swap edge. It also keeps loading for the next 35 cycles while the current row shifts out. The result is judged one window later: byte 0 of the following row must come out as the first eight bits, and the row in flight must be unchanged. Windows of length 295 and 296 are also placed next to each other to check the underrun decision at its edge.

// File: rtl/ovh_tx_pkg.sv
package ovh_tx_pkg;
  localparam int unsigned STREAMS   = 12;
  localparam int unsigned SLOTS     = 3;
  localparam int unsigned GUARD_CYC = 4;
  localparam int unsigned ROW_BYTES = STREAMS * SLOTS;
  localparam int unsigned ROW_BITS  = ROW_BYTES * 8;
  localparam int unsigned IDX_W     = $clog2(ROW_BYTES + 1);
endpackage

// File: rtl/ovh_win_timer.sv
module ovh_win_timer #(
  parameter int unsigned GUARD    = 4,
  parameter int unsigned ROW_BITS = 288,
  parameter int unsigned LEN_W    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_start_i,
  input  logic win_end_i,
  input  logic busy_i,
  output logic launch_o,
  output logic underrun_o
);
  localparam int unsigned MIN_LEN = ROW_BITS + 2 * GUARD;
  localparam int unsigned GC_W    = $clog2(GUARD) + 1;

  logic [LEN_W-1:0] len_cnt_q, meas_q;
  logic             counting_q, meas_vld_q, guard_q, underrun_q;
  logic [GC_W-1:0]  gcnt_q;
  logic             can_start, len_ok;

  assign can_start  = win_start_i && !busy_i && !guard_q && meas_vld_q;
  assign len_ok     = meas_q >= LEN_W'(MIN_LEN);
  assign launch_o   = guard_q && (gcnt_q == GC_W'(GUARD - 1));
  assign underrun_o = underrun_q;

  // window length measurement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_cnt_q  <= '0;
      meas_q     <= '0;
      counting_q <= 1'b0;
      meas_vld_q <= 1'b0;
    end else if (win_start_i) begin
      len_cnt_q  <= LEN_W'(1);
      counting_q <= 1'b1;
    end else if (counting_q) begin
      if (win_end_i) begin
        meas_q     <= len_cnt_q + 1'b1;
        meas_vld_q <= 1'b1;
        counting_q <= 1'b0;
      end else if (len_cnt_q != '1) begin
        len_cnt_q <= len_cnt_q + 1'b1;
      end
    end
  end

  // leading guard band and launch decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q    <= 1'b0;
      gcnt_q     <= '0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= can_start && !len_ok;
      if (can_start && len_ok) begin
        guard_q <= 1'b1;
        gcnt_q  <= GC_W'(1);
      end else if (launch_o) begin
        guard_q <= 1'b0;
        gcnt_q  <= '0;
      end else if (guard_q) begin
        gcnt_q <= gcnt_q + 1'b1;
      end
    end
  end

  a_r2_launch_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> !busy_i);
  a_r6_underrun_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
endmodule

// File: rtl/ovh_row_buf.sv
module ovh_row_buf #(
  parameter int unsigned BYTES = 36,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       load_byte_i,
  input  logic             swap_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o
);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(BYTES);

  logic [7:0]       mem_q [2][BYTES];
  logic             sel_q;
  logic [IDX_W-1:0] wr_ptr_q;
  logic             rd_bank;

  // during the swap cycle the incoming bank is read
  assign rd_bank   = swap_i ? ~sel_q : sel_q;
  assign rd_byte_o = mem_q[rd_bank][rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      wr_ptr_q <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < int'(BYTES); i++)
          mem_q[b][i] <= '0;
    end else if (swap_i) begin
      sel_q <= ~sel_q;
      if (load_i) begin
        mem_q[sel_q][0] <= load_byte_i;
        wr_ptr_q        <= IDX_W'(1);
      end else begin
        wr_ptr_q <= '0;
      end
    end else if (load_i && wr_ptr_q < FULL) begin
      mem_q[~sel_q][wr_ptr_q] <= load_byte_i;
      wr_ptr_q                <= wr_ptr_q + 1'b1;
    end
  end

  a_r10_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr_q <= FULL);
  a_r8_ptr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> wr_ptr_q <= IDX_W'(1));
endmodule

// File: rtl/ovh_serializer.sv
module ovh_serializer #(
  parameter int unsigned BYTES = 36,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [7:0]       rd_byte_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             sd_o,
  output logic             en_o,
  output logic             fp_o
);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(BYTES - 1);

  logic             busy_q, sd_q, en_q, fp_q;
  logic [IDX_W-1:0] byte_q, nbyte;
  logic [2:0]       bit_q, nbit;
  logic             last;

  always_comb begin
    if (bit_q == 3'd0) begin
      nbyte = byte_q + 1'b1;
      nbit  = 3'd7;
    end else begin
      nbyte = byte_q;
      nbit  = bit_q - 1'b1;
    end
  end

  assign last     = (byte_q == LAST_BYTE) && (bit_q == 3'd0);
  assign rd_idx_o = launch_i ? '0 : ((busy_q && !last) ? nbyte : '0);
  assign busy_o   = busy_q;
  assign sd_o     = sd_q;
  assign en_o     = en_q;
  assign fp_o     = fp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      byte_q <= '0;
      bit_q  <= 3'd7;
      sd_q   <= 1'b0;
      en_q   <= 1'b0;
      fp_q   <= 1'b0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      byte_q <= '0;
      bit_q  <= 3'd7;
      sd_q   <= rd_byte_i[7];
      en_q   <= 1'b1;
      fp_q   <= 1'b1;
    end else begin
      fp_q <= 1'b0;
      if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          en_q   <= 1'b0;
          sd_q   <= 1'b0;
        end else begin
          byte_q <= nbyte;
          bit_q  <= nbit;
          sd_q   <= rd_byte_i[nbit];
        end
      end
    end
  end

  a_r4_fp_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |-> en_o);
  a_r5_sd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !sd_o);
  a_r2_rise_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> fp_o);
  a_r4_fp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);
endmodule

// File: rtl/ovh_row_tx.sv
module ovh_row_tx
  import ovh_tx_pkg::*;
#(
  parameter int unsigned N_STREAMS = STREAMS,
  parameter int unsigned N_SLOTS   = SLOTS,
  parameter int unsigned GUARD     = GUARD_CYC,
  parameter int unsigned LEN_W     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       win_start_i,
  input  logic       win_end_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  output logic       ovh_sd_o,
  output logic       ovh_en_o,
  output logic       ovh_fp_o,
  output logic       underrun_o
);
  localparam int unsigned NBYTES = N_STREAMS * N_SLOTS;
  localparam int unsigned NBITS  = NBYTES * 8;
  localparam int unsigned NIDX_W = $clog2(NBYTES + 1);

  logic              launch, busy;
  logic [NIDX_W-1:0] rd_idx;
  logic [7:0]        rd_byte;

  ovh_win_timer #(.GUARD(GUARD), .ROW_BITS(NBITS), .LEN_W(LEN_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_start_i(win_start_i),
    .win_end_i  (win_end_i),
    .busy_i     (busy),
    .launch_o   (launch),
    .underrun_o (underrun_o)
  );

  ovh_row_buf #(.BYTES(NBYTES), .IDX_W(NIDX_W)) i_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_byte_i(load_byte_i),
    .swap_i     (launch),
    .rd_idx_i   (rd_idx),
    .rd_byte_o  (rd_byte)
  );

  ovh_serializer #(.BYTES(NBYTES), .IDX_W(NIDX_W)) i_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .rd_byte_i(rd_byte),
    .rd_idx_o (rd_idx),
    .busy_o   (busy),
    .sd_o     (ovh_sd_o),
    .en_o     (ovh_en_o),
    .fp_o     (ovh_fp_o)
  );

  a_r6_no_row_on_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !ovh_fp_o);
endmodule

// File: tb/test_ovh_row_tx.sv
module test_ovh_row_tx;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       win_start = 1'b0, win_end = 1'b0, load = 1'b0;
  logic [7:0] load_byte = '0;
  logic       sd, en, fp, underrun;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovh_row_tx i_ovh_row_tx (
    .clk_i(clk), .rst_ni(rst_ni), .win_start_i(win_start), .win_end_i(win_end),
    .load_i(load), .load_byte_i(load_byte),
    .ovh_sd_o(sd), .ovh_en_o(en), .ovh_fp_o(fp), .underrun_o(underrun)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 53 + i * 29 + 7) ^ (seed << 4));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(en == 1'b0 && sd == 1'b0, "R5 idle quiet", {en, sd}, 0);
    end
  endtask

  task automatic load_idle(input int seed);
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      load = 1'b1;
      load_byte = pat(seed, i);
    end
    @(negedge clk);
    load = 1'b0;
  endtask

  // one window of len cycles; outputs sampled at negedge k reflect edge k-1
  task automatic run_window(input int len, input bit exp_send, input bit exp_err,
                            input int exp_seed, input int ld_k0, input int ld_seed,
                            input int ld_cnt, input string tag);
    for (int k = 0; k < len; k++) begin
      bit e_en, e_fp, e_sd, e_err;
      @(negedge clk);
      e_en  = exp_send && k >= 4 && k < 292;
      e_fp  = exp_send && k == 4;
      e_sd  = e_en ? pat(exp_seed, (k - 4) / 8)[7 - ((k - 4) % 8)] : 1'b0;
      e_err = exp_err && k == 1;
      if (k > 0) begin
        chk(en == e_en, {tag, " R2/R11 enable"}, en, e_en);
        chk(fp == e_fp, {tag, " R4 frame pulse"}, fp, e_fp);
        chk(sd == e_sd, {tag, " R3/R5 data bit"}, sd, e_sd);
        chk(underrun == e_err, {tag, " R6/R7 underrun"}, underrun, e_err);
      end
      win_start = (k == 0);
      win_end   = (k == len - 1);
      load      = (k >= ld_k0 && k < ld_k0 + ld_cnt);
      load_byte = load ? pat(ld_seed, k - ld_k0) : 8'h00;
    end
    @(negedge clk);
    chk(en == 1'b0 && underrun == 1'b0, {tag, " R11 tail"}, en, 0);
    win_start = 1'b0;
    win_end   = 1'b0;
    load      = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk({en, sd, fp, underrun} == 4'b0, "R1 in reset", {en, sd, fp, underrun}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({en, sd, fp, underrun} == 4'b0, "R1 after reset", {en, sd, fp, underrun}, 0);
  endtask

  task automatic t_unmeasured();  // R7
    load_idle(1);
    run_window(300, 1'b0, 1'b0, 0, 0, 0, 0, "R7 first window");
    gap(4);
  endtask

  task automatic t_load_on_swap();  // R2 R3 R4 R9: load of byte 0 on swap edge
    run_window(300, 1'b1, 1'b0, 1, 3, 2, 36, "R9 swap load");
    gap(4);
  endtask

  task automatic t_overflow();  // R8 R10: 37 loads while row 2 shifts
    run_window(295, 1'b1, 1'b0, 2, 50, 3, 37, "R8 R10 load during send");
    gap(4);
  endtask

  task automatic t_underrun();  // R6: predicted 295 < 296
    run_window(300, 1'b0, 1'b1, 0, 0, 0, 0, "R6 underrun");
    gap(4);
  endtask

  task automatic t_boundary();  // R6 R10 R11: row 3 intact, then 296 accepted
    run_window(296, 1'b1, 1'b0, 3, 10, 4, 36, "R10 row3");
    gap(4);
    run_window(300, 1'b1, 1'b0, 4, 0, 0, 0, "R6 R11 min window");
    gap(4);
  endtask

  initial begin
    t_reset();
    t_unmeasured();
    t_load_on_swap();
    t_overflow();
    t_underrun();
    t_boundary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule